// File: doc/BRIEF.md
# Event Manager Master Controller

This block is the master side of an event synchronization scheme that spans several crates. It keeps one global event counter. When it accepts a trigger it raises a system-wide busy (inhibit) line, adds one to the counter, and puts the low eight bits of the new count on a parallel event-number bus. Two cycles after the bus value changes it sends a one-cycle strobe, which tells the remote slave crates that a new event has been taken. Each slave answers on its own ready line once it can take the next event. The master releases busy only after every enabled slave has answered.

Each slave's answer is caught in a sticky per-slave flag, so a single-cycle pulse is enough. All flags are cleared when the next event is accepted. Slaves switched off in the enable vector count as ready. An optional watchdog raises a sticky alarm after a programmable number of wait cycles and records which enabled slaves are still missing. Busy stays asserted while the alarm is up, so a slave that answers late still completes the event normally.

Top module: `event_mgr_master`

## Requirements
- R1: While reset (synchronous, active high) is applied and in the first cycle after it, busy, strobe and alarm are 0, and the event count and event number are 0.
- R2: A trigger that is high while the block is idle is accepted. Busy goes high combinationally in that same cycle, and the event count shows the incremented value in the next cycle.
- R3: The event number bus equals the low 8 bits of the new count from the cycle after acceptance onward. It changes only while busy is high and holds its value for the rest of the busy period.
- R4: Exactly one strobe is produced per accepted event. It is high for one cycle, three cycles after the accepting cycle (that is, two cycles after the bus updates), and busy is high during that cycle.
- R5: Trigger pulses that arrive while busy is high are ignored. The count does not change and no extra strobe is produced.
- R6: A ready pulse in cycle j is latched. Busy falls in cycle max(j+2, k+5), where k is the accepting cycle and j is the cycle of the last missing enabled slave's pulse.
- R7: Slaves whose enable bit is 0 are treated as ready. With all slaves disabled, busy falls in cycle k+5.
- R8: Latched ready flags are cleared when a new event is accepted. An answer given during the previous event does not count toward the current one.
- R9: If the timeout limit L is nonzero and enabled slaves are still missing, alarm rises in cycle k+4+L. Alarm mask then holds the enabled slaves that had not answered (bit i = slave i). L = 0 disables the alarm.
- R10: Busy stays high while alarm is set and ready is incomplete. A late answer still releases busy. Alarm stays set until the next accepted event clears it.
- R11: The event number wraps modulo 256 while the full-width count keeps incrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trigIn | input | 1 | Trigger accept request |
| slaveEnable | input | NUM_SLAVES | Per-slave participation mask |
| slaveReady | input | NUM_SLAVES | Per-slave ready handshake pulses |
| timeoutLimit | input | TMO_W | Wait cycles before alarm; 0 disables |
| busy | output | 1 | System inhibit |
| evtNum | output | NUM_W | Low bits of the current event count |
| evtStrobe | output | 1 | One-cycle event-number valid strobe |
| eventCount | output | CNT_W | Full global event counter |
| alarm | output | 1 | Sticky handshake timeout flag |
| alarmMask | output | NUM_SLAVES | Enabled slaves missing at timeout |

## Verification
Two conditions are hard to reach from the ports. The first is a stale handshake: one slave answered during the previous event but stays silent during the current one. The bench runs an event where every slave answers and then an event where slave 0 withholds its pulse, and it checks that busy is held. The second is a timeout that is followed by a late answer. The bench programs a short limit, leaves two slaves silent past it, checks the alarm cycle and the mask, then lets those slaves answer and checks that busy is released while the alarm stays set.

// File: rtl/emm_pkg.sv
`timescale 1ns/1ps
package emm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clearEvt;    // new event accepted: clear sticky flags, timeout, alarm
    logic bumpCount;   // increment global counter, load event number
    logic latchReady;  // capture slave ready pulses
    logic tmoRun;      // waiting phase: run timeout counter
  } emm_ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_HOLD   = 3'd2,
    ST_STROBE = 3'd3,
    ST_WAIT   = 3'd4
  } emm_state_e;
endpackage

// File: rtl/emm_ctrl.sv
`timescale 1ns/1ps
module emm_ctrl
  import emm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     trigIn,
  input  logic     allReady,
  output emm_ctl_t ctl,
  output logic     busy,
  output logic     evtStrobe
);
  emm_state_e state, stateNext;
  logic accept;

  assign accept = trigIn && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (accept) stateNext = ST_SETTLE;
      ST_SETTLE: stateNext = ST_HOLD;
      ST_HOLD:   stateNext = ST_STROBE;
      ST_STROBE: stateNext = ST_WAIT;
      ST_WAIT:   if (allReady) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    ctl.clearEvt   = accept;
    ctl.bumpCount  = accept;
    ctl.latchReady = (state != ST_IDLE);
    ctl.tmoRun     = (state == ST_WAIT);
  end

  assign busy      = (state != ST_IDLE) || accept;
  assign evtStrobe = (state == ST_STROBE);
endmodule

// File: rtl/emm_datapath.sv
`timescale 1ns/1ps
module emm_datapath
  import emm_pkg::*;
#(
  parameter int NUM_SLAVES = 5,
  parameter int CNT_W      = 24,
  parameter int NUM_W      = 8,
  parameter int TMO_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  emm_ctl_t              ctl,
  input  logic [NUM_SLAVES-1:0] slaveEnable,
  input  logic [NUM_SLAVES-1:0] slaveReady,
  input  logic [TMO_W-1:0]      timeoutLimit,
  output logic                  allReady,
  output logic [CNT_W-1:0]      eventCount,
  output logic [NUM_W-1:0]      evtNum,
  output logic                  alarm,
  output logic [NUM_SLAVES-1:0] alarmMask
);
  localparam logic [TMO_W-1:0] TMO_MAX = '1;

  logic [CNT_W-1:0]      countNext;
  logic [NUM_SLAVES-1:0] gotReady;
  logic [TMO_W-1:0]      tmoCnt;
  logic                  tmoHit;

  assign countNext = eventCount + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      eventCount <= '0;
      evtNum     <= '0;
    end else if (ctl.bumpCount) begin
      eventCount <= countNext;
      evtNum     <= countNext[NUM_W-1:0];
    end
  end

  // sticky per-slave handshake flags
  for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_slave
    always_ff @(posedge clk) begin
      if (rst || ctl.clearEvt)                  gotReady[s] <= 1'b0;
      else if (ctl.latchReady && slaveReady[s]) gotReady[s] <= 1'b1;
    end
  end

  assign allReady = &(gotReady | ~slaveEnable);

  assign tmoHit = ctl.tmoRun && !allReady && !alarm &&
                  (timeoutLimit != '0) && (tmoCnt == timeoutLimit - TMO_W'(1));

  always_ff @(posedge clk) begin
    if (rst || ctl.clearEvt)
      tmoCnt <= '0;
    else if (ctl.tmoRun && !allReady && tmoCnt != TMO_MAX)
      tmoCnt <= tmoCnt + TMO_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clearEvt) begin
      alarm     <= 1'b0;
      alarmMask <= '0;
    end else if (tmoHit) begin
      alarm     <= 1'b1;
      alarmMask <= slaveEnable & ~gotReady;
    end
  end
endmodule

// File: rtl/event_mgr_master.sv
`timescale 1ns/1ps
module event_mgr_master
  import emm_pkg::*;
#(
  parameter int NUM_SLAVES = 5,
  parameter int CNT_W      = 24,
  parameter int NUM_W      = 8,
  parameter int TMO_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trigIn,
  input  logic [NUM_SLAVES-1:0] slaveEnable,
  input  logic [NUM_SLAVES-1:0] slaveReady,
  input  logic [TMO_W-1:0]      timeoutLimit,
  output logic                  busy,
  output logic [NUM_W-1:0]      evtNum,
  output logic                  evtStrobe,
  output logic [CNT_W-1:0]      eventCount,
  output logic                  alarm,
  output logic [NUM_SLAVES-1:0] alarmMask
);
  emm_ctl_t ctl;
  logic     allReady;

  emm_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .trigIn    (trigIn),
    .allReady  (allReady),
    .ctl       (ctl),
    .busy      (busy),
    .evtStrobe (evtStrobe)
  );

  emm_datapath #(
    .NUM_SLAVES (NUM_SLAVES),
    .CNT_W      (CNT_W),
    .NUM_W      (NUM_W),
    .TMO_W      (TMO_W)
  ) dp_i (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .slaveEnable  (slaveEnable),
    .slaveReady   (slaveReady),
    .timeoutLimit (timeoutLimit),
    .allReady     (allReady),
    .eventCount   (eventCount),
    .evtNum       (evtNum),
    .alarm        (alarm),
    .alarmMask    (alarmMask)
  );
endmodule

// File: rtl/emm_checker.sv
`timescale 1ns/1ps
module emm_checker #(
  parameter int NUM_SLAVES = 5,
  parameter int CNT_W      = 24,
  parameter int NUM_W      = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  evtStrobe,
  input logic [NUM_W-1:0]      evtNum,
  input logic [CNT_W-1:0]      eventCount,
  input logic                  alarm,
  input logic [NUM_SLAVES-1:0] alarmMask,
  input logic [NUM_SLAVES-1:0] slaveEnable
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(eventCount) |-> (eventCount == $past(eventCount) + CNT_W'(1)));

  // R3
  evtnum_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(evtNum) |-> busy);

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    evtStrobe |=> !evtStrobe);

  // R4
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    evtStrobe |-> busy);

  // R9
  alarm_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> (alarmMask != '0) && ((alarmMask & ~slaveEnable) == '0));

  // R10
  alarm_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> busy);
endmodule

bind event_mgr_master emm_checker #(
  .NUM_SLAVES (NUM_SLAVES),
  .CNT_W      (CNT_W),
  .NUM_W      (NUM_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .evtStrobe   (evtStrobe),
  .evtNum      (evtNum),
  .eventCount  (eventCount),
  .alarm       (alarm),
  .alarmMask   (alarmMask),
  .slaveEnable (slaveEnable)
);

// File: tb/event_mgr_master_tb_top.sv
`timescale 1ns/1ps
module event_mgr_master_tb_top;
  localparam int NS = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trigIn = 1'b0;
  logic [NS-1:0] slaveEnable = '1;
  logic [NS-1:0] slaveReady = '0;
  logic [15:0]   timeoutLimit = '0;
  logic          busy;
  logic [7:0]    evtNum;
  logic          evtStrobe;
  logic [23:0]   eventCount;
  logic          alarm;
  logic [NS-1:0] alarmMask;

  int vecs = 0;
  int errs = 0;
  int expCount = 0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  event_mgr_master dut_i (
    .clk(clk), .rst(rst), .trigIn(trigIn), .slaveEnable(slaveEnable),
    .slaveReady(slaveReady), .timeoutLimit(timeoutLimit), .busy(busy),
    .evtNum(evtNum), .evtStrobe(evtStrobe), .eventCount(eventCount),
    .alarm(alarm), .alarmMask(alarmMask)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // driver: accept in cycle k, returns at cycle k+1
  task automatic fire();
    trigIn = 1'b1;
    #1;
    check(busy == 1'b1, "R2 busy same cycle", int'(busy), 1);
    expCount++;
    expQ.push_back(8'(expCount));
    step();
    trigIn = 1'b0;
    check(eventCount == 24'(expCount), "R2 count", int'(eventCount), expCount);
    check(evtNum == 8'(expCount), "R3 evtNum", int'(evtNum), expCount % 256);
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    slaveReady = m;
    step();
    slaveReady = '0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && evtStrobe) begin
      if (expQ.size() == 0) begin
        vecs++; errs++;
        $display("FAIL R4 extra strobe actual=%0d expected=none", evtNum);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(evtNum == e, "R4 strobe data", int'(evtNum), int'(e));
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    step(4);
    check(busy == 0 && evtStrobe == 0 && alarm == 0, "R1 ctl outs", int'(busy), 0);
    rst = 1'b0;
    step();
    check(eventCount == 0 && evtNum == 0, "R1 counters", int'(eventCount), 0);
    check(busy == 0 && alarm == 0, "R1 after reset", int'(busy), 0);

    // basic event, all answer at k+4
    fire();                                        // k+1
    check(evtStrobe == 0, "R4 no early strobe", int'(evtStrobe), 0);
    step();                                        // k+2
    check(evtStrobe == 0, "R4 no strobe k+2", int'(evtStrobe), 0);
    step();                                        // k+3
    check(evtStrobe == 1, "R4 strobe k+3", int'(evtStrobe), 1);
    step();                                        // k+4
    check(evtStrobe == 0 && busy == 1, "R4 one cycle", int'(evtStrobe), 0);
    pulse('1);                                     // k+5
    check(busy == 1, "R6 busy k+5", int'(busy), 1);
    step();                                        // k+6
    check(busy == 0, "R6 release k+6", int'(busy), 0);

    // staggered answers and a trigger while busy
    step(2);
    fire();                                        // k+1
    pulse(5'b00001);                               // k+2
    pulse(5'b00010);                               // k+3
    trigIn = 1'b1;
    step();                                        // k+4
    trigIn = 1'b0;
    check(eventCount == 24'(expCount), "R5 trigger ignored", int'(eventCount), expCount);
    check(evtNum == 8'(expCount), "R3 evtNum held", int'(evtNum), expCount % 256);
    step(2);                                       // k+6
    check(busy == 1, "R6 waits for all", int'(busy), 1);
    pulse(5'b11100);                               // k+7
    check(busy == 1, "R6 busy k+7", int'(busy), 1);
    step();                                        // k+8
    check(busy == 0, "R6 release k+8", int'(busy), 0);

    // masking
    step(2);
    slaveEnable = '0;
    fire();
    step(3);                                       // k+4
    check(busy == 1, "R7 busy k+4", int'(busy), 1);
    step();                                        // k+5
    check(busy == 0, "R7 all disabled release", int'(busy), 0);
    slaveEnable = 5'b00101;
    step();
    fire();
    pulse(5'b00101);                               // k+2
    step(2);                                       // k+4
    check(busy == 1, "R7 partial busy k+4", int'(busy), 1);
    step();                                        // k+5
    check(busy == 0, "R7 partial release", int'(busy), 0);

    // per-event clearing of sticky flags
    slaveEnable = '1;
    step();
    fire();
    pulse('1);
    step(3);                                       // k+5
    check(busy == 0, "R8 event A done", int'(busy), 0);
    step();
    fire();
    pulse(5'b11110);                               // k+2
    step(6);                                       // k+8
    check(busy == 1, "R8 stale answer not counted", int'(busy), 1);
    pulse(5'b00001);                               // k+9
    check(busy == 1, "R8 busy k+9", int'(busy), 1);
    step();
    check(busy == 0, "R8 release", int'(busy), 0);

    // timeout with late answer
    timeoutLimit = 16'd6;
    step();
    fire();                                        // k+1
    pulse(5'b00111);                               // k+2
    step(7);                                       // k+9
    check(alarm == 0, "R9 no alarm k+9", int'(alarm), 0);
    step();                                        // k+10
    check(alarm == 1, "R9 alarm k+10", int'(alarm), 1);
    check(alarmMask == 5'b11000, "R9 alarm mask", int'(alarmMask), 24);
    check(busy == 1, "R10 busy with alarm", int'(busy), 1);
    step(3);                                       // k+13
    pulse(5'b11000);                               // k+14
    step();                                        // k+15
    check(busy == 0, "R10 late answer release", int'(busy), 0);
    check(alarm == 1, "R10 alarm sticky", int'(alarm), 1);
    step();
    fire();
    check(alarm == 0, "R10 alarm cleared by accept", int'(alarm), 1'b0);
    pulse('1);
    step(3);
    check(busy == 0, "R10 clean event", int'(busy), 0);

    // timeout disabled
    timeoutLimit = '0;
    fire();
    step(40);
    check(alarm == 0 && busy == 1, "R9 limit zero no alarm", int'(alarm), 0);
    pulse('1);
    step();
    check(busy == 0, "R9 release after long wait", int'(busy), 0);

    // wrap of event number
    slaveEnable = '0;
    while (expCount < 258) begin
      fire();
      step(4);
    end
    check(evtNum == 8'd2, "R11 evtNum wrap", int'(evtNum), 2);
    check(eventCount == 24'd258, "R11 count past 255", int'(eventCount), 258);
    step(4);
    check(expQ.size() == 0, "R4 one strobe per event", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule